// File: doc/BRIEF.md
# Counted Character Transmit Front End

This block sits between a 32-bit register port and a byte serializer, and it is the transmit front end of a UART. Software first sets how many characters make up the next transfer, then writes the characters one at a time. The block queues each character in a small FIFO and offers it to the serializer through a valid/ready handshake. When the serializer accepts the last character of the counted transfer, a sticky transmit-ready interrupt status bit is set.

Software clears that bit with a code written to a command register; writing the status register has no effect on it. A transmitter-empty status bit shows when the FIFO holds nothing. The interrupt output is the status bits filtered by a mask register. If a new count is written while a transfer is still running, the unsent rest of that transfer is dropped. Character writes that go past the count, or that arrive while the FIFO is full, are ignored.

The register port is combinational on reads and takes writes on the rising clock edge. The register offsets are 0x040 for the count, 0x0A4 for status, 0x0A8 for command, 0x0B0 for the mask, 0x0B4 for interrupt status and 0x100 for the FIFO.

Top module: `cnt_tx_front`

## Requirements
- R1: After reset, ser_valid and irq are 0. Reads return 0 at 0x040, 0x0B0 and 0x0B4, and 0x008 (bit 3 set) at 0x0A4.
- R2: A write to 0x040 loads wdata[CNT_W-1:0] as both the send budget and the accept budget. A read of 0x040 returns the number of characters of the current transfer not yet taken by the serializer.
- R3: A write to 0x100 queues wdata[7:0]. Queued characters appear on ser_data in write order, with ser_valid high from the cycle after the write. A character leaves the queue on each clock edge where ser_valid and ser_ready are both high.
- R4: Writes to 0x100 are ignored once the accept budget is 0.
- R5: Writes to 0x100 while the FIFO holds DEPTH characters are dropped and do not use up budget.
- R6: Bit 7 of 0x0B4 is set on the edge where the serializer takes the last counted character, and never before that edge.
- R7: A write to 0x0A8 with wdata[11:8]==3 clears bit 7 of 0x0B4. Other codes leave it unchanged. A set in the same cycle wins over the clear.
- R8: Bit 3 of 0x0A4 reads 1 exactly when the FIFO holds no character.
- R9: A write to 0x040 empties the FIFO and cancels the unsent rest of the transfer, and leaves bit 7 of 0x0B4 unchanged. It takes priority over a handshake in the same cycle, and that character is not counted.
- R10: The mask register at 0x0B0 holds wdata[7:0]. irq is the OR of the bits of 0x0B4 ANDed with the mask, so writing 0 masks everything.
- R11: Reads of 0x0A8, 0x100 and unmapped offsets return 0. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| ser_data | output | 8 | Character offered to the serializer |
| ser_valid | output | 1 | ser_data holds a character |
| ser_ready | input | 1 | Serializer takes the character this edge |
| irq | output | 1 | Masked interrupt request |

## Verification
Every register write takes effect on the edge where it is presented. After that edge, reads and the handshake outputs show the new state at once. A queued character is offered one cycle after its write. The ready bit and irq change right after the edge that completes the last handshake. The bench drives each cycle on the falling edge and lets the logic settle. It compares against a model stepped once per rising edge: a queue holding the expected characters, together with its budget counters. Directed sequences cover overfill, writes past the count, cancellation and same-cycle set/clear. A long random run with a fixed seed covers the rest.

// File: rtl/cnt_tx_front.sv
module cnt_tx_front #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 16,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic [7:0]    ser_data,
  output logic          ser_valid,
  input  logic          ser_ready,
  output logic          irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int OW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] A_CNT  = AW'(12'h040);
  localparam logic [AW-1:0] A_STAT = AW'(12'h0A4);
  localparam logic [AW-1:0] A_CMD  = AW'(12'h0A8);
  localparam logic [AW-1:0] A_MASK = AW'(12'h0B0);
  localparam logic [AW-1:0] A_ISR  = AW'(12'h0B4);
  localparam logic [AW-1:0] A_FIFO = AW'(12'h100);

  logic [7:0]       mem [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic [OW-1:0]    occ;
  logic [CNT_W-1:0] accept_left, send_left;
  logic             tx_ready;
  logic [7:0]       mask;

  wire wr_cnt  = reg_wr && reg_addr == A_CNT;
  wire wr_fifo = reg_wr && reg_addr == A_FIFO;
  wire wr_cmd  = reg_wr && reg_addr == A_CMD;
  wire wr_mask = reg_wr && reg_addr == A_MASK;
  wire full    = occ == OW'(DEPTH);
  wire push    = wr_fifo && !wr_cnt && accept_left != '0 && !full;
  wire pop     = ser_valid && ser_ready && !wr_cnt;
  wire last    = pop && send_left == CNT_W'(1);
  wire clear   = wr_cmd && reg_wdata[11:8] == 4'h3;

  assign ser_valid = occ != '0;
  assign ser_data  = mem[rp];
  assign irq       = |({tx_ready, 7'b0} & mask);

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= reg_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      occ <= '0;
      accept_left <= '0;
      send_left <= '0;
    end else if (wr_cnt) begin
      wp <= '0;
      rp <= '0;
      occ <= '0;
      accept_left <= reg_wdata[CNT_W-1:0];
      send_left <= reg_wdata[CNT_W-1:0];
    end else begin
      if (push) begin
        wp <= bump(wp);
        accept_left <= accept_left - 1'b1;
      end
      if (pop) begin
        rp <= bump(rp);
        send_left <= send_left - 1'b1;
      end
      occ <= occ + OW'(push) - OW'(pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ready <= 1'b0;
      mask <= '0;
    end else begin
      if (last)       tx_ready <= 1'b1;
      else if (clear) tx_ready <= 1'b0;
      if (wr_mask) mask <= reg_wdata[7:0];
    end
  end

  always_comb begin
    case (reg_addr)
      A_CNT:   reg_rdata = 32'(send_left);
      A_STAT:  reg_rdata = {28'b0, !ser_valid, 3'b0};
      A_MASK:  reg_rdata = {24'b0, mask};
      A_ISR:   reg_rdata = {24'b0, tx_ready, 7'b0};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cnt_tx_front_chk.sv
module cnt_tx_front_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 16,
  parameter int OW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push,
  input logic             wr_cnt,
  input logic             clear,
  input logic             tx_ready,
  input logic             ser_valid,
  input logic             ser_ready,
  input logic             irq,
  input logic [7:0]       mask,
  input logic [OW-1:0]    occ,
  input logic [CNT_W-1:0] accept_left,
  input logic [CNT_W-1:0] send_left
);
  p_valid_after_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> ser_valid);
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OW'(DEPTH));
  p_budget_r2: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'(occ) == send_left - accept_left);
  p_ready_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready) |-> $past(ser_valid && ser_ready && !wr_cnt));
  p_ready_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready && !clear |=> tx_ready);
  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> !ser_valid);
  p_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mask == 8'h00 |-> !irq);
endmodule

bind cnt_tx_front cnt_tx_front_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .push(push), .wr_cnt(wr_cnt), .clear(clear),
  .tx_ready(tx_ready), .ser_valid(ser_valid), .ser_ready(ser_ready), .irq(irq),
  .mask(mask), .occ(occ), .accept_left(accept_left), .send_left(send_left)
);

// File: tb/cnt_tx_front_bench.sv
module cnt_tx_front_bench;
  localparam int DEPTH = 16;
  localparam logic [11:0] A_CNT = 12'h040, A_STAT = 12'h0A4, A_CMD = 12'h0A8,
                          A_MASK = 12'h0B0, A_ISR = 12'h0B4, A_FIFO = 12'h100;

  logic clk = 0, rst_n = 0, reg_wr = 0, ser_ready = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [7:0] ser_data;
  logic ser_valid, irq;

  always #4 clk = ~clk;

  cnt_tx_front #(.DEPTH(DEPTH), .CNT_W(16), .AW(12)) u_cnt_tx_front (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ser_data(ser_data),
    .ser_valid(ser_valid), .ser_ready(ser_ready), .irq(irq));

  int checks = 0, fails = 0;
  logic [7:0] q[$];
  int m_acc = 0, m_send = 0;
  bit m_rdy = 0;
  logic [7:0] m_mask = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [11:0] a);
    case (a)
      A_CNT:   return 32'(m_send);
      A_STAT:  return (q.size() == 0) ? 32'h8 : 32'h0;
      A_MASK:  return {24'b0, m_mask};
      A_ISR:   return m_rdy ? 32'h80 : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

  task automatic cyc(input bit wr, input logic [11:0] a, input logic [31:0] d,
                     input bit rdy, input string tag);
    bit pop, setr;
    int occ0;
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; ser_ready = rdy;
    #1;
    chk(ser_valid == (q.size() != 0), "R3 valid", 32'(ser_valid), 32'(q.size() != 0));
    if (q.size() != 0) chk(ser_data == q[0], "R3 data", 32'(ser_data), 32'(q[0]));
    chk(irq == (m_rdy && m_mask[7]), "R10 irq", 32'(irq), 32'(m_rdy && m_mask[7]));
    if (!wr) chk(reg_rdata == m_read(a), tag, reg_rdata, m_read(a));
    pop = (q.size() != 0) && rdy;
    setr = 0;
    occ0 = q.size();
    if (wr && a == A_CNT) begin
      q.delete();
      m_acc = int'(d[15:0]);
      m_send = int'(d[15:0]);
    end else begin
      if (pop) begin
        void'(q.pop_front());
        m_send--;
        if (m_send == 0) setr = 1;
      end
      if (wr && a == A_FIFO && m_acc > 0 && occ0 < DEPTH) begin
        q.push_back(d[7:0]);
        m_acc--;
      end
    end
    if (setr) m_rdy = 1;
    else if (wr && a == A_CMD && d[11:8] == 4'h3) m_rdy = 0;
    if (wr && a == A_MASK) m_mask = d[7:0];
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input bit rdy = 0);
    cyc(1, a, d, rdy, "");
  endtask
  task automatic rd(input logic [11:0] a, input string tag, input bit rdy = 0);
    cyc(0, a, 0, rdy, tag);
  endtask
  task automatic drain(input int n);
    for (int i = 0; i < n; i++) cyc(0, A_STAT, 0, 1, "R8 drain");
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset state
    rd(A_CNT, "R1 cnt"); rd(A_STAT, "R1 stat"); rd(A_ISR, "R1 isr"); rd(A_MASK, "R1 mask");
    // R2/R3/R6 basic transfer
    wr(A_MASK, 32'h80);
    wr(A_CNT, 3);
    rd(A_CNT, "R2 cnt loaded");
    wr(A_FIFO, 32'h41); wr(A_FIFO, 32'h42); wr(A_FIFO, 32'h143);
    rd(A_STAT, "R8 not empty"); rd(A_ISR, "R6 not yet");
    drain(2);
    rd(A_ISR, "R6 one left");
    drain(3);
    rd(A_ISR, "R6 set"); rd(A_CNT, "R2 cnt done");
    // R7 command codes
    wr(A_CMD, 32'h400); rd(A_ISR, "R7 other code");
    wr(A_STAT, 32'hFF); rd(A_ISR, "R7 status write");
    wr(A_CMD, 32'h300); rd(A_ISR, "R7 cleared");
    // R4 beyond count
    wr(A_CNT, 2);
    wr(A_FIFO, 1); wr(A_FIFO, 2); wr(A_FIFO, 3);
    rd(A_CNT, "R4 cnt");
    drain(4);
    rd(A_ISR, "R4 isr"); rd(A_STAT, "R4 empty");
    // R5 full
    wr(A_CMD, 32'h300);
    wr(A_CNT, 20);
    for (int i = 0; i < 20; i++) wr(A_FIFO, 32'(8'h60 + i));
    drain(18);
    rd(A_CNT, "R5 remainder"); rd(A_ISR, "R5 not done");
    for (int i = 0; i < 4; i++) wr(A_FIFO, 32'(8'h90 + i));
    drain(5);
    rd(A_ISR, "R5 done");
    // R9 cancel, ready bit kept
    wr(A_CNT, 5);
    wr(A_FIFO, 7); wr(A_FIFO, 8); wr(A_FIFO, 9);
    rd(A_STAT, "R9 queued");
    wr(A_CNT, 1, 1);
    rd(A_STAT, "R9 flushed"); rd(A_CNT, "R9 cnt"); rd(A_ISR, "R9 ready kept");
    wr(A_FIFO, 32'hAA);
    drain(2);
    // R7 set wins
    wr(A_CMD, 32'h300);
    wr(A_CNT, 1); wr(A_FIFO, 32'h55);
    cyc(1, A_CMD, 32'h300, 1, "");
    rd(A_ISR, "R7 set wins");
    // R10 masking
    wr(A_MASK, 0); rd(A_MASK, "R10 mask");
    rd(A_ISR, "R10 status kept");
    wr(A_MASK, 32'hFF);
    // R11 unmapped
    wr(12'h0C0, 32'hFFFF_FFFF);
    rd(12'h0C0, "R11 unmapped"); rd(A_CMD, "R11 cmd"); rd(A_FIFO, "R11 fifo");
    rd(A_MASK, "R11 mask kept"); rd(A_CNT, "R11 cnt kept");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int k = int'($urandom_range(0, 99));
      bit r = ($urandom_range(0, 3) != 0);
      if (k < 4)       cyc(1, A_CNT, $urandom_range(0, 24), r, "");
      else if (k < 40) cyc(1, A_FIFO, $urandom, r, "");
      else if (k < 45) cyc(1, A_CMD, {20'b0, 4'($urandom_range(2, 4)), 8'h0}, r, "");
      else if (k < 47) cyc(1, A_MASK, $urandom, r, "");
      else if (k < 55) cyc(0, A_CNT, 0, r, "R2 random cnt");
      else if (k < 65) cyc(0, A_STAT, 0, r, "R8 random stat");
      else if (k < 75) cyc(0, A_ISR, 0, r, "R6 random isr");
      else             cyc(0, A_MASK, 0, r, "R10 random mask");
    end
    summary();
  end
endmodule